// File: doc/BRIEF.md
# Serial Cross-Correlation Engine

This block computes every lag of the cross-correlation of two equal-length vectors of signed samples. Software or an upstream unit first writes both vectors into two small sample banks, one word per load strobe. A start pulse then sets off a run. One multiplier steps through each lag's overlap window, one product per clock. For each lag it emits a single accumulated result with a valid strobe and a lag index. After the last lag it gives a one-cycle done pulse.

The block walks the lags in a fixed order. Index 0 pairs the first element of the first vector with the last element of the second vector. The overlap then grows to the full vector at the centre index and shrinks again, until the last index pairs the last element of the first vector with the first element of the second. The samples are real-valued integers, so the conjugation of the first vector needs no logic.

Top module: `xcorr_engine`

## Requirements
- R1: After reset, `busy`, `res_valid` and `done` are all low.
- R2: A load strobe with `ld_sel` = 0 writes `ld_data` into the first vector, and with `ld_sel` = 1 into the second vector, at element `ld_addr`. Addresses from 0 to N-1 are valid. A load strobe with `ld_addr` >= N is dropped.
- R3: The result carried with lag index k equals the sum over j of a[j]*b[j+N-1-k], taken over every j for which both indices lie in 0..N-1. The values are signed two's complement, and the sum is sign-extended to ACCW bits.
- R4: One run emits 2N-1 results. Their lag indices are 0, 1, ..., 2N-2 in that order, and `res_valid` is high for exactly one cycle per result.
- R5: Lag k takes w(k) = N-|N-1-k| clock cycles. With start sampled at edge 0, the result for lag k is on the outputs just after edge C(k)+1, where C(k) is the sum of w over lags 0..k. A whole run therefore spends N*N cycles on products.
- R6: `done` pulses high for one cycle. It comes one cycle after the result with lag index 2N-2.
- R7: `busy` goes high on the edge that accepts a start and falls on the edge that raises `done`. A start seen while `busy` is high is ignored and does not disturb the run under way.
- R8: A load strobe seen while `busy` is high changes neither bank. Later runs use the vectors as they stood before it.
- R9: The results for full-scale inputs (all -128, or +127 against -128) are exact and do not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Sample write strobe |
| ld_sel | input | 1 | Bank select: 0 first vector, 1 second vector |
| ld_addr | input | AW (4) | Element index within the selected vector |
| ld_data | input | DW (8) | Signed sample to store |
| start | input | 1 | Run request, one cycle |
| busy | output | 1 | A run is in progress |
| res_valid | output | 1 | Result strobe, one cycle per lag |
| res_lag | output | LW (5) | Lag index of the current result |
| res_data | output | ACCW (20) | Signed correlation value |
| done | output | 1 | One-cycle pulse after the final result |

## Verification
The checker assumes that results only ever appear as part of a run that an accepted start began. It also assumes that a run always finishes before the next one starts, so the expected lag index can simply follow the result strobe and wrap after index 2N-2. The bench drives inputs only on falling edges. It issues new starts only after `done`, except for deliberate start and load pulses that it injects while `busy` is high to show they are ignored. Load addresses stay within 0..N-1, except for one deliberate out-of-range write. The random vectors cover the full signed 8-bit range.

// File: rtl/xcorr_pkg.sv
package xcorr_pkg;
  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;
endpackage

// File: rtl/xcorr_bank.sv
module xcorr_bank #(
  parameter int DEPTH = 9,
  parameter int AW    = 4,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/xcorr_lag_seq.sv
module xcorr_lag_seq
  import xcorr_pkg::*;
#(
  parameter int N  = 9,
  parameter int AW = 4,
  parameter int LW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  output logic          iss_vld,
  output logic          iss_first,
  output logic          iss_last,
  output logic [LW-1:0] iss_lag,
  output logic [AW-1:0] addr_a,
  output logic [AW-1:0] addr_b
);
  localparam int NOUT = 2 * N - 1;
  localparam logic [LW-1:0] LAG_MID  = LW'(N - 1);
  localparam logic [LW-1:0] LAG_LAST = LW'(NOUT - 1);

  seq_state_e    state;
  logic [LW-1:0] lag;
  logic [LW-1:0] pos;
  logic [LW-1:0] base_a, base_b, wlen;
  logic [LW-1:0] sum_a, sum_b;

  always_comb begin
    if (lag <= LAG_MID) begin
      base_a = '0;
      base_b = LAG_MID - lag;
      wlen   = lag + LW'(1);
    end else begin
      base_a = lag - LAG_MID;
      base_b = '0;
      wlen   = LAG_LAST - lag + LW'(1);
    end
    sum_a = base_a + pos;
    sum_b = base_b + pos;
  end

  assign iss_vld   = (state == SEQ_RUN);
  assign iss_first = (pos == '0);
  assign iss_last  = (pos == wlen - LW'(1));
  assign iss_lag   = lag;
  assign addr_a    = sum_a[AW-1:0];
  assign addr_b    = sum_b[AW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= SEQ_IDLE;
      lag   <= '0;
      pos   <= '0;
    end else begin
      case (state)
        SEQ_IDLE: begin
          if (go) begin
            state <= SEQ_RUN;
            lag   <= '0;
            pos   <= '0;
          end
        end
        SEQ_RUN: begin
          if (iss_last) begin
            pos <= '0;
            if (lag == LAG_LAST) state <= SEQ_IDLE;
            else                 lag   <= lag + LW'(1);
          end else begin
            pos <= pos + LW'(1);
          end
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/xcorr_mac.sv
module xcorr_mac #(
  parameter int N    = 9,
  parameter int DW   = 8,
  parameter int LW   = 5,
  parameter int ACCW = 20
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   iss_vld,
  input  logic                   iss_first,
  input  logic                   iss_last,
  input  logic [LW-1:0]          iss_lag,
  input  logic [DW-1:0]          smp_a,
  input  logic [DW-1:0]          smp_b,
  output logic                   res_valid,
  output logic [LW-1:0]          res_lag,
  output logic signed [ACCW-1:0] res_data,
  output logic                   done
);
  localparam int PW = 2 * DW;
  localparam logic [LW-1:0] LAG_LAST = LW'(2 * N - 2);

  logic          st_vld, st_first, st_last;
  logic [LW-1:0] st_lag;
  logic signed [ACCW-1:0] acc;
  logic signed [PW-1:0]   prod;
  logic signed [ACCW-1:0] prod_x, nxt;

  always_comb begin
    prod   = $signed(smp_a) * $signed(smp_b);
    prod_x = ACCW'(prod);
    nxt    = st_first ? prod_x : acc + prod_x;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_vld    <= 1'b0;
      st_first  <= 1'b0;
      st_last   <= 1'b0;
      st_lag    <= '0;
      acc       <= '0;
      res_valid <= 1'b0;
      res_lag   <= '0;
      res_data  <= '0;
      done      <= 1'b0;
    end else begin
      st_vld   <= iss_vld;
      st_first <= iss_first;
      st_last  <= iss_last;
      st_lag   <= iss_lag;
      if (st_vld) acc <= nxt;
      res_valid <= st_vld && st_last;
      if (st_vld && st_last) begin
        res_lag  <= st_lag;
        res_data <= nxt;
      end
      done <= res_valid && (res_lag == LAG_LAST);
    end
  end
endmodule

// File: rtl/xcorr_engine.sv
module xcorr_engine #(
  parameter int N    = 9,
  parameter int DW   = 8,
  parameter int ACCW = 20,
  parameter int AW   = $clog2(N),
  parameter int LW   = $clog2(2 * N - 1)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   ld_en,
  input  logic                   ld_sel,
  input  logic [AW-1:0]          ld_addr,
  input  logic [DW-1:0]          ld_data,
  input  logic                   start,
  output logic                   busy,
  output logic                   res_valid,
  output logic [LW-1:0]          res_lag,
  output logic signed [ACCW-1:0] res_data,
  output logic                   done
);
  localparam logic [LW-1:0] LAG_LAST = LW'(2 * N - 2);
  localparam logic [AW:0]   DEPTH_X  = (AW+1)'(N);

  logic          go;
  logic          iss_vld, iss_first, iss_last;
  logic [LW-1:0] iss_lag;
  logic [AW-1:0] rd_addr [2];
  logic [DW-1:0] rd_data [2];
  logic          addr_ok;

  assign go      = start && !busy;
  assign addr_ok = {1'b0, ld_addr} < DEPTH_X;

  always_ff @(posedge clk) begin
    if (rst)                                     busy <= 1'b0;
    else if (go)                                 busy <= 1'b1;
    else if (res_valid && res_lag == LAG_LAST)   busy <= 1'b0;
  end

  xcorr_lag_seq #(.N(N), .AW(AW), .LW(LW)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .go        (go),
    .iss_vld   (iss_vld),
    .iss_first (iss_first),
    .iss_last  (iss_last),
    .iss_lag   (iss_lag),
    .addr_a    (rd_addr[0]),
    .addr_b    (rd_addr[1])
  );

  for (genvar g = 0; g < 2; g++) begin : g_bank
    logic we;
    assign we = ld_en && !busy && addr_ok && (ld_sel == 1'(g));
    xcorr_bank #(.DEPTH(N), .AW(AW), .DW(DW)) u_bank (
      .clk   (clk),
      .we    (we),
      .waddr (ld_addr),
      .wdata (ld_data),
      .raddr (rd_addr[g]),
      .rdata (rd_data[g])
    );
  end

  xcorr_mac #(.N(N), .DW(DW), .LW(LW), .ACCW(ACCW)) u_mac (
    .clk       (clk),
    .rst       (rst),
    .iss_vld   (iss_vld),
    .iss_first (iss_first),
    .iss_last  (iss_last),
    .iss_lag   (iss_lag),
    .smp_a     (rd_data[0]),
    .smp_b     (rd_data[1]),
    .res_valid (res_valid),
    .res_lag   (res_lag),
    .res_data  (res_data),
    .done      (done)
  );
endmodule

// File: rtl/xcorr_engine_chk.sv
module xcorr_engine_chk #(
  parameter int N  = 9,
  parameter int LW = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          busy,
  input logic          res_valid,
  input logic [LW-1:0] res_lag,
  input logic          done
);
  localparam logic [LW-1:0] LAG_LAST = LW'(2 * N - 2);

  logic [LW-1:0] want_lag;

  always_ff @(posedge clk) begin
    if (rst)                                        want_lag <= '0;
    else if (res_valid && res_lag == LAG_LAST)      want_lag <= '0;
    else if (res_valid)                             want_lag <= want_lag + LW'(1);
  end

  p_lag_seq_r4: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> res_lag == want_lag);

  p_done_after_last_r6: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(res_valid) && $past(res_lag) == LAG_LAST);

  p_done_single_r6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_result_in_run_r7: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> busy);

  p_idle_at_done_r7: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  p_busy_ends_with_done_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);
endmodule

bind xcorr_engine xcorr_engine_chk #(.N(N), .LW(LW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .busy      (busy),
  .res_valid (res_valid),
  .res_lag   (res_lag),
  .done      (done)
);

// File: tb/xcorr_engine_test.sv
module xcorr_engine_test;
  localparam int N    = 9;
  localparam int DW   = 8;
  localparam int ACCW = 20;
  localparam int AW   = 4;
  localparam int LW   = 5;
  localparam int NOUT = 2 * N - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ld_en = 1'b0, ld_sel = 1'b0, start = 1'b0;
  logic [AW-1:0] ld_addr = '0;
  logic [DW-1:0] ld_data = '0;
  logic busy, res_valid, done;
  logic [LW-1:0] res_lag;
  logic signed [ACCW-1:0] res_data;

  int total = 0;
  int bad = 0;
  int va [N];
  int vb [N];

  always #2 clk = ~clk;

  xcorr_engine #(.N(N), .DW(DW), .ACCW(ACCW)) uut (
    .clk(clk), .rst(rst), .ld_en(ld_en), .ld_sel(ld_sel), .ld_addr(ld_addr),
    .ld_data(ld_data), .start(start), .busy(busy), .res_valid(res_valid),
    .res_lag(res_lag), .res_data(res_data), .done(done)
  );

  function automatic int wlen(int k);
    int d = N - 1 - k;
    return N - (d < 0 ? -d : d);
  endfunction

  function automatic int model(int k);
    int s = 0;
    for (int j = 0; j < N; j++) begin
      int m = j + N - 1 - k;
      if (m >= 0 && m < N) s += va[j] * vb[m];
    end
    return s;
  endfunction

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic put(bit sel, int addr, int val);
    @(negedge clk);
    ld_en = 1'b1; ld_sel = sel; ld_addr = AW'(addr); ld_data = DW'(val);
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic load_all();
    for (int i = 0; i < N; i++) put(1'b0, i, va[i]);
    for (int i = 0; i < N; i++) put(1'b1, i, vb[i]);
  endtask

  // inject=1: pulse start and a load to bank 0 while busy (R7, R8)
  task automatic run(bit inject);
    int cyc = 1;
    int nres = 0;
    int cum = 0;
    bit fin = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check("R7 busy after start", int'(busy), 1);
    while (!fin && cyc < 400) begin
      if (res_valid) begin
        cum += wlen(nres);
        check("R3 value", int'(res_data), model(nres));
        check("R4 lag", int'(res_lag), nres);
        check("R5 timing", cyc, cum + 2);
        if (nres == N - 1)
          check("R3 centre equals full dot product", int'(res_data), model(N - 1));
        nres++;
      end
      if (done) begin
        check("R6 done count", nres, NOUT);
        check("R6 done cycle", cyc, N * N + 3);
        check("R7 busy low at done", int'(busy), 0);
        fin = 1;
      end
      if (inject && cyc == 5) begin
        start = 1'b1; ld_en = 1'b1; ld_sel = 1'b0; ld_addr = '0; ld_data = 8'h55;
      end else begin
        start = 1'b0; ld_en = 1'b0;
      end
      @(negedge clk);
      cyc++;
      if (fin) begin
        check("R6 done one cycle", int'(done), 0);
        check("R7 no restart", int'(busy), 0);
      end
    end
    if (!fin) check("R6 done seen", 0, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20250611));
    repeat (3) @(negedge clk);
    check("R1 busy", int'(busy), 0);
    check("R1 res_valid", int'(res_valid), 0);
    check("R1 done", int'(done), 0);
    rst = 1'b0;

    // R2 R3: directed reference vectors
    for (int i = 0; i < N; i++) va[i] = i + 1;
    vb = '{3, 4, 5, 6, 7, 8, 9, 2, 1};
    load_all();
    run(1'b0);

    // R7 R8: start and load pulses during a run are ignored
    run(1'b1);
    run(1'b0);

    // R2: out-of-range address dropped (must not alias an element)
    put(1'b0, N, 99);
    put(1'b0, 15, 99);
    run(1'b0);

    // R9: full-scale values
    for (int i = 0; i < N; i++) begin va[i] = -128; vb[i] = -128; end
    load_all();
    run(1'b0);
    for (int i = 0; i < N; i++) begin va[i] = 127; vb[i] = -128; end
    load_all();
    run(1'b0);

    // R3: random vectors across the signed range
    for (int t = 0; t < 4; t++) begin
      for (int i = 0; i < N; i++) begin
        va[i] = int'($signed(8'($urandom)));
        vb[i] = int'($signed(8'($urandom)));
      end
      load_all();
      run(1'b0);
    end

    // R2: single-element rewrite, only that element changes
    va[3] = -7;
    put(1'b0, 3, -7);
    vb[N-1] = 100;
    put(1'b1, N - 1, 100);
    run(1'b0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule